// File: doc/BRIEF.md
# Text-Mode Raster Timing and Pixel Serializer

This block drives a character-cell display from one dot clock. A 4-bit prescaler splits the dot stream into character cells seven dots wide. A chain of counters then walks the cell columns, the scan lines inside a text row, and the text rows of a frame. From these counters the block forms the address of the current cell in an external character memory. It takes the returned code and forms the address of the matching glyph row in an external font memory. It then shifts that row out as a one-bit pixel stream. The counters also give registered horizontal and vertical sync.

Blanking comes from two places. During horizontal retrace, the top bit of the font address is driven low. That lower half of the font memory is empty (it reads all ones), so nothing is drawn. The other blanking causes force the loaded row to all ones. These causes are:

- the vertical retrace rows,
- the two spacer scans at the bottom of every text row,
- a blinking character while the blink phase is high,
- a CPU access request, brought in through a two-stage synchronizer on the character clock.

A font bit of 0 is a lit dot.

Top module: `crt_char_timing`

## Requirements
- R1: The dot prescaler reloads 16 minus CHAR_DOTS (9 by default) after its count of 15, so one character cell lasts exactly CHAR_DOTS dot clocks (7 by default).
- R2: The column counter advances once per cell and returns to 0 after COLS_TOTAL-1 (127 by default). The scan counter advances once per column wrap and counts modulo SCANS_PER_ROW (10).
- R3: hsync is high for exactly the cell periods in which the column count equals COLS_VISIBLE (80), delayed by one dot clock.
- R4: Cells captured on scan 8 or 9 of a text row display no lit dots. Scan bits [2:0] choose the glyph row.
- R5: The line counter advances once per SCANS_PER_ROW scans and wraps after ROWS_TOTAL (26) lines. vsync is high, delayed by one dot, while the line count equals ROWS_VISIBLE (24). Lines at or above ROWS_VISIBLE display nothing.
- R6: font_addr is {select, code[6:0], scan[2:0]}, with select in bit 10. Select is 0 for a cell captured at a column count of COLS_VISIBLE or more, and 1 otherwise.
- R7: A cell whose code has bit 7 set is dark while the blink phase is 1. The blink phase is the top bit of a BLINK_BITS-wide counter that advances once per frame.
- R8: cpu_req is sampled on each character-clock edge through two registers. A cell captured while the second register is 1 is dark.
- R9: A cell whose code is read during column period k is captured at the end of that period. Its font row is loaded at the end of the next period. It is shown during the period after that, one dot per clock, font bit 7-d at dot d, with video = NOT(font bit). The next row is fetched while the current one is shifted out.
- R10: char_addr equals line*COLS_VISIBLE + column while column < COLS_VISIBLE and line < ROWS_VISIBLE, and 0 otherwise.
- R11: While rst is high, all counters clear, hsync and vsync are 0, video is 0, and char_addr and font_addr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Asynchronous CPU access request; blanks the display while active |
| char_data | input | 8 | Code read from the character memory; bit 7 is the blink attribute |
| font_data | input | 8 | Glyph row read from the font memory; a 0 bit is a lit dot |
| char_addr | output | ADDR_W | Character memory address |
| font_addr | output | 11 | Font memory address |
| video | output | 1 | Serial pixel, 1 = lit |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |

## Verification
The bench runs a reduced raster: 16 columns with 10 visible, and 6 lines with 4 visible. It covers five complete frames and compares every output on every dot with a model built from the dot count alone.

The sweep goes after several specific faults:

- A prescaler that reloads the wrong value stretches every cell and drifts all addresses.
- An off-by-one in the two-cell pixel pipeline shows each glyph under its neighbour's column.
- A reversed shift order mirrors each glyph.
- Missing retrace selection or missing spacer-scan blanking leaves lit dots in regions that must be dark.

CPU request windows are placed so that their edges fall inside text rows. A synchronizer with one stage too many or too few then blanks the wrong cells. The blink phase is covered through all four values of its counter, so an inverted or mistimed phase shows as characters lit in the wrong frames.

// File: rtl/crt_timing_pkg.sv
package crt_timing_pkg;

  localparam int GLYPH_W    = 7;
  localparam int ROW_SEL_W  = 3;
  localparam int FONT_BYTE  = 8;
  localparam int FONT_AW    = 1 + GLYPH_W + ROW_SEL_W;

  // One captured character cell, held while its glyph row is fetched.
  typedef struct packed {
    logic [GLYPH_W-1:0]   glyph;
    logic [ROW_SEL_W-1:0] row;
    logic                 hretrace;
    logic                 dark;
  } cell_t;

  function automatic int unsigned text_offset(input int unsigned line,
                                              input int unsigned col,
                                              input int unsigned cols);
    return line * cols + col;
  endfunction

  function automatic logic [FONT_AW-1:0] font_index(input logic sel,
                                                    input logic [GLYPH_W-1:0] glyph,
                                                    input logic [ROW_SEL_W-1:0] row);
    return {sel, glyph, row};
  endfunction

  // Dot d of a cell shows font bit (FONT_BYTE-1-d): leftmost dot is the MSB.
  function automatic int unsigned pixel_bit(input int unsigned dot);
    return FONT_BYTE - 1 - dot;
  endfunction

endpackage

// File: rtl/crt_dot_prescaler.sv
module crt_dot_prescaler #(
  parameter int DOT_W     = 4,
  parameter int CHAR_DOTS = 7
) (
  input  logic             clk,
  input  logic             rst,
  output logic [DOT_W-1:0] dot_cnt,
  output logic [DOT_W-1:0] dot_idx,
  output logic             char_tick
);
  localparam int               LOAD_I = (1 << DOT_W) - CHAR_DOTS;
  localparam logic [DOT_W-1:0] LOAD   = DOT_W'(LOAD_I);
  localparam logic [DOT_W-1:0] TERM   = '1;

  assign char_tick = (dot_cnt == TERM);
  assign dot_idx   = dot_cnt - LOAD;

  always_ff @(posedge clk) begin
    if (rst)            dot_cnt <= LOAD;
    else if (char_tick) dot_cnt <= LOAD;
    else                dot_cnt <= dot_cnt + DOT_W'(1);
  end
endmodule

// File: rtl/crt_raster_counters.sv
module crt_raster_counters #(
  parameter int COLS_TOTAL    = 128,
  parameter int SCANS_PER_ROW = 10,
  parameter int ROWS_TOTAL    = 26,
  parameter int BLINK_BITS    = 4,
  parameter int COL_W         = $clog2(COLS_TOTAL),
  parameter int SCAN_W        = $clog2(SCANS_PER_ROW),
  parameter int LINE_W        = $clog2(ROWS_TOTAL)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              char_tick,
  output logic [COL_W-1:0]  col,
  output logic [SCAN_W-1:0] scan,
  output logic [LINE_W-1:0] line,
  output logic              blink,
  output logic              frame_end
);
  localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(COLS_TOTAL - 1);
  localparam logic [SCAN_W-1:0] SCAN_LAST = SCAN_W'(SCANS_PER_ROW - 1);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(ROWS_TOTAL - 1);

  logic col_end, scan_end;

  assign col_end   = char_tick && (col == COL_LAST);
  assign scan_end  = col_end && (scan == SCAN_LAST);
  assign frame_end = scan_end && (line == LINE_LAST);

  always_ff @(posedge clk) begin
    if (rst)            col <= '0;
    else if (col_end)   col <= '0;
    else if (char_tick) col <= col + COL_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)           scan <= '0;
    else if (scan_end) scan <= '0;
    else if (col_end)  scan <= scan + SCAN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)            line <= '0;
    else if (frame_end) line <= '0;
    else if (scan_end)  line <= line + LINE_W'(1);
  end

  generate
    if (BLINK_BITS > 0) begin : g_blink
      logic [BLINK_BITS-1:0] frames;
      always_ff @(posedge clk) begin
        if (rst)            frames <= '0;
        else if (frame_end) frames <= frames + BLINK_BITS'(1);
      end
      assign blink = frames[BLINK_BITS-1];
    end else begin : g_no_blink
      assign blink = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/crt_pixel_path.sv
module crt_pixel_path
  import crt_timing_pkg::*;
#(
  parameter int DOT_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 char_tick,
  input  logic [DOT_W-1:0]     dot_idx,
  input  cell_t                cell_in,
  input  logic [FONT_BYTE-1:0] font_data,
  output logic [FONT_AW-1:0]   font_addr,
  output logic                 held_hretrace,
  output logic                 video
);
  cell_t                held;
  logic [FONT_BYTE-1:0] shifter;

  always_ff @(posedge clk) begin
    if (rst) begin
      held    <= '{glyph: '0, row: '0, hretrace: 1'b1, dark: 1'b1};
      shifter <= '1;
    end else if (char_tick) begin
      held    <= cell_in;
      shifter <= held.dark ? '1 : font_data;
    end
  end

  assign held_hretrace = held.hretrace;
  assign font_addr     = font_index(!held.hretrace, held.glyph, held.row);
  assign video         = !shifter[3'(pixel_bit(32'(dot_idx)))];
endmodule

// File: rtl/crt_char_timing.sv
module crt_char_timing
  import crt_timing_pkg::*;
#(
  parameter int DOT_W         = 4,
  parameter int CHAR_DOTS     = 7,
  parameter int COLS_TOTAL    = 128,
  parameter int COLS_VISIBLE  = 80,
  parameter int SCANS_PER_ROW = 10,
  parameter int FONT_ROWS     = 8,
  parameter int ROWS_TOTAL    = 26,
  parameter int ROWS_VISIBLE  = 24,
  parameter int BLINK_BITS    = 4,
  localparam int ADDR_W       = $clog2(COLS_VISIBLE * ROWS_VISIBLE)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_req,
  input  logic [7:0]         char_data,
  input  logic [7:0]         font_data,
  output logic [ADDR_W-1:0]  char_addr,
  output logic [FONT_AW-1:0] font_addr,
  output logic               video,
  output logic               hsync,
  output logic               vsync
);
  localparam int COL_W  = $clog2(COLS_TOTAL);
  localparam int SCAN_W = $clog2(SCANS_PER_ROW);
  localparam int LINE_W = $clog2(ROWS_TOTAL);

  logic [DOT_W-1:0]  dot_cnt, dot_idx;
  logic              char_tick;
  logic [COL_W-1:0]  col;
  logic [SCAN_W-1:0] scan;
  logic [LINE_W-1:0] line;
  logic              blink, frame_end;
  logic [1:0]        cpu_sync;
  logic              in_hretrace, in_vretrace, spacer_scan, blink_dark, visible;
  logic              held_hretrace;
  cell_t             cell_in;

  crt_dot_prescaler #(.DOT_W(DOT_W), .CHAR_DOTS(CHAR_DOTS)) u_pre (
    .clk(clk), .rst(rst), .dot_cnt(dot_cnt), .dot_idx(dot_idx), .char_tick(char_tick)
  );

  crt_raster_counters #(
    .COLS_TOTAL(COLS_TOTAL), .SCANS_PER_ROW(SCANS_PER_ROW),
    .ROWS_TOTAL(ROWS_TOTAL), .BLINK_BITS(BLINK_BITS),
    .COL_W(COL_W), .SCAN_W(SCAN_W), .LINE_W(LINE_W)
  ) u_cnt (
    .clk(clk), .rst(rst), .char_tick(char_tick), .col(col), .scan(scan),
    .line(line), .blink(blink), .frame_end(frame_end)
  );

  // Two-stage synchronizer for the CPU request, stepped by the character clock.
  always_ff @(posedge clk) begin
    if (rst)            cpu_sync <= '0;
    else if (char_tick) cpu_sync <= {cpu_sync[0], cpu_req};
  end

  assign in_hretrace = (col >= COL_W'(COLS_VISIBLE));
  assign in_vretrace = (line >= LINE_W'(ROWS_VISIBLE));
  assign spacer_scan = (scan >= SCAN_W'(FONT_ROWS));
  assign blink_dark  = char_data[7] && blink;
  assign visible     = !in_hretrace && !in_vretrace;

  assign char_addr = visible
                   ? ADDR_W'(text_offset(32'(line), 32'(col), COLS_VISIBLE))
                   : '0;

  assign cell_in.glyph    = char_data[GLYPH_W-1:0];
  assign cell_in.row      = scan[ROW_SEL_W-1:0];
  assign cell_in.hretrace = in_hretrace;
  assign cell_in.dark     = in_vretrace || spacer_scan || cpu_sync[1] || blink_dark;

  crt_pixel_path #(.DOT_W(DOT_W)) u_pix (
    .clk(clk), .rst(rst), .char_tick(char_tick), .dot_idx(dot_idx),
    .cell_in(cell_in), .font_data(font_data), .font_addr(font_addr),
    .held_hretrace(held_hretrace), .video(video)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync <= 1'b0;
      vsync <= 1'b0;
    end else begin
      hsync <= (col == COL_W'(COLS_VISIBLE));
      vsync <= (line == LINE_W'(ROWS_VISIBLE));
    end
  end
endmodule

// File: rtl/crt_timing_checker.sv
module crt_timing_checker #(
  parameter int DOT_W         = 4,
  parameter int CHAR_DOTS     = 7,
  parameter int COLS_TOTAL    = 128,
  parameter int COLS_VISIBLE  = 80,
  parameter int SCANS_PER_ROW = 10,
  parameter int ROWS_TOTAL    = 26,
  parameter int ROWS_VISIBLE  = 24
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          char_tick,
  input logic [DOT_W-1:0]              dot_cnt,
  input logic [$clog2(COLS_TOTAL)-1:0] col,
  input logic [$clog2(SCANS_PER_ROW)-1:0] scan,
  input logic [$clog2(ROWS_TOTAL)-1:0] line,
  input logic                          hsync,
  input logic                          vsync,
  input logic                          font_sel
);
  localparam int LOAD = (1 << DOT_W) - CHAR_DOTS;

  p_tick_isolated_r1: assert property (@(posedge clk) disable iff (rst)
    char_tick |=> !char_tick);

  p_dot_floor_r1: assert property (@(posedge clk) disable iff (rst)
    32'(dot_cnt) >= LOAD);

  p_col_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (char_tick && 32'(col) == COLS_TOTAL - 1) |=> (col == '0));

  p_hsync_start_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync) |-> (32'(col) == COLS_VISIBLE));

  p_scan_bound_r4: assert property (@(posedge clk) disable iff (rst)
    32'(scan) < SCANS_PER_ROW);

  p_vsync_start_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(vsync) |-> (32'(line) == ROWS_VISIBLE));

  p_retrace_select_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(char_tick) && $past(32'(col) >= COLS_VISIBLE)) |-> !font_sel);
endmodule

bind crt_char_timing crt_timing_checker #(
  .DOT_W(DOT_W), .CHAR_DOTS(CHAR_DOTS), .COLS_TOTAL(COLS_TOTAL),
  .COLS_VISIBLE(COLS_VISIBLE), .SCANS_PER_ROW(SCANS_PER_ROW),
  .ROWS_TOTAL(ROWS_TOTAL), .ROWS_VISIBLE(ROWS_VISIBLE)
) u_chk (
  .clk(clk), .rst(rst), .char_tick(char_tick), .dot_cnt(dot_cnt),
  .col(col), .scan(scan), .line(line), .hsync(hsync), .vsync(vsync),
  .font_sel(font_addr[crt_timing_pkg::FONT_AW-1])
);

// File: tb/crt_char_timing_test.sv
module crt_char_timing_test;
  localparam int CT = 16, CV = 10, SR = 10, FR = 8, RT = 6, RV = 4, BB = 2, CD = 7;
  localparam int AW = $clog2(CV * RV);
  localparam int FRAME_DOTS = CT * SR * RT * CD;
  localparam int RUN = 5 * FRAME_DOTS;

  logic clk = 0, rst = 1, cpu_req = 0;
  logic [7:0] char_data, font_data;
  logic [AW-1:0] char_addr;
  logic [10:0] font_addr;
  logic video, hsync, vsync;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  crt_char_timing #(.COLS_TOTAL(CT), .COLS_VISIBLE(CV), .SCANS_PER_ROW(SR),
    .FONT_ROWS(FR), .ROWS_TOTAL(RT), .ROWS_VISIBLE(RV), .BLINK_BITS(BB)) uut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .char_data(char_data),
    .font_data(font_data), .char_addr(char_addr), .font_addr(font_addr),
    .video(video), .hsync(hsync), .vsync(vsync));

  // External memory models.
  function automatic int ram_code(input int a);
    return (((a % 5) == 2) ? 128 : 0) + ((a * 11 + 5) % 128);
  endfunction
  function automatic int font_row(input int a);
    if (a < 1024) return 255;
    return (a * 29 + 60) % 256;
  endfunction
  assign char_data = 8'(ram_code(int'(char_addr)));
  assign font_data = 8'(font_row(int'(font_addr)));

  function automatic bit req_window(input int n);
    return (n >= 8000 && n < 9500) || (n >= 20000 && n < 20050);
  endfunction

  function automatic int col_of(input int c);  return c % CT;               endfunction
  function automatic int scan_of(input int c); return (c / CT) % SR;        endfunction
  function automatic int line_of(input int c); return (c / (CT * SR)) % RT; endfunction
  function automatic int addr_of(input int c);
    if (col_of(c) < CV && line_of(c) < RV) return line_of(c) * CV + col_of(c);
    return 0;
  endfunction
  function automatic int fa_of(input int c);
    int code = ram_code(addr_of(c));
    return ((col_of(c) >= CV) ? 0 : 1024) + (code % 128) * 8 + (scan_of(c) % 8);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_state(input int n);
    int c = n / CD, d = n % CD;
    int exp_v = 0;
    string tag = "R9 pixel";
    // R10 R1 R2: address follows the counters, one cell per CD dots
    check("R10 R1 R2 char_addr", int'(char_addr), addr_of(c));
    // R6 R4: glyph row address of the captured cell
    check("R6 R4 font_addr", int'(font_addr), (c >= 1) ? fa_of(c - 1) : 0);
    // R3 R5: registered sync, one dot late
    check("R3 hsync", int'(hsync), (n >= 1 && col_of((n - 1) / CD) == CV) ? 1 : 0);
    check("R5 vsync", int'(vsync), (n >= 1 && line_of((n - 1) / CD) == RV) ? 1 : 0);
    if (c >= 2) begin
      int m = c - 2;
      int code = ram_code(addr_of(m));
      bit cpu = (m >= 2) && req_window(7 * m - 8);
      bit blk = (code >= 128) && (((m / (FRAME_DOTS / CD)) >> (BB - 1)) % 2 == 1);
      bit spc = scan_of(m) >= FR;
      bit vrt = line_of(m) >= RV;
      bit hrt = col_of(m) >= CV;
      if (cpu)      tag = "R8 cpu blank";
      else if (blk) tag = "R7 blink";
      else if (spc) tag = "R4 spacer scan";
      else if (vrt) tag = "R5 vblank";
      else if (hrt) tag = "R6 hretrace";
      if (!(cpu || blk || spc || vrt || hrt))
        exp_v = ((font_row(fa_of(m)) >> (7 - d)) % 2 == 0) ? 1 : 0;
    end
    check(tag, int'(video), exp_v);
  endtask

  initial begin
    #(150000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    check("R11 reset hsync", int'(hsync), 0);
    check("R11 reset vsync", int'(vsync), 0);
    check("R11 reset video", int'(video), 0);
    check("R11 reset char_addr", int'(char_addr), 0);
    check("R11 reset font_addr", int'(font_addr), 0);
    rst = 0;
    for (int n = 0; n < RUN; n++) begin
      check_state(n);
      cpu_req = req_window(n);
      @(negedge clk);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule